// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small microcontroller core sleeps and what stays powered while it does. Software writes a four-bit control register. One bit asks for idle, one asks for full power-down, and two further bits allow the serial interrupt and external interrupt 0 to end a power-down. A separate one-bit write tells the block whether the oscillator may stop during power-down. From the current mode the block drives registered clock enables for the core, the PLL, the peripherals, the oscillator and the interval timer. It also drives a high-impedance control for the analog output, an override flag for the two external bus strobes (address latch and program fetch), and the level the strobes are held at while the override is active.

Idle stops only the core clock and holds both strobes high. Power-down also stops the PLL and the peripherals, floats the analog output and holds both strobes low. Idle ends on any enabled interrupt line. Power-down ends only on the interval-timer line, or on a serial or external-0 line whose wake enable is set. A wake clears both request bits, restores every clock on the same edge, and raises a one-cycle pulse towards the interrupt logic. A synchronous reset ends either mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the control register and oscillator-off bit read as zero. Every clock enable is 1, `aout_hiz`, `strobe_ovr` and `wake_pulse` are 0, and both strobe levels are 1.
- R2: One clock after control bit 0 (idle request) reads 1 in run mode, `core_clk_en` goes to 0. The PLL, peripheral, oscillator and timer enables stay 1, `aout_hiz` stays 0, `strobe_ovr` goes to 1 and both strobe levels are 1.
- R3: One clock after control bit 1 (power-down request) reads 1 in run mode, the core, PLL and peripheral enables go to 0. `aout_hiz` and `strobe_ovr` go to 1 and both strobe levels go to 0.
- R4: In power-down, `osc_en` and `tick_clk_en` both equal the inverse of the oscillator-off bit. In run and idle they are 1.
- R5: When bits 0 and 1 are both 1, power-down is entered, not idle.
- R6: In idle, a 1 on any line of `irq_req` wakes the block.
- R7: In power-down, line `TICK_IDX` always wakes the block. Line `SER_IDX` wakes it only when control bit 2 is 1, and line `EXT0_IDX` only when control bit 3 is 1. All other lines have no effect.
- R8: A wake ends the mode on the edge after the qualifying line is seen. On that edge control bits 0 and 1 clear, bits 2 and 3 keep their values, all clock enables and the run-mode pin values return, and `wake_pulse` is 1 for exactly that one cycle.
- R9: Writes to the control register and to the oscillator-off bit are ignored while the block is in idle or power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W (4) | Control write data: bit 0 idle, bit 1 power-down, bit 2 serial wake enable, bit 3 external-0 wake enable |
| pll_wr | input | 1 | Oscillator-off bit write strobe |
| pll_osc_off | input | 1 | Value written to the oscillator-off bit |
| irq_req | input | NUM_IRQ (8) | Enabled interrupt lines, active high |
| ctl_rdata | output | CTL_W (4) | Current control register value |
| osc_off_rd | output | 1 | Current oscillator-off bit |
| core_clk_en | output | 1 | Core clock enable |
| pll_clk_en | output | 1 | PLL enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| tick_clk_en | output | 1 | Interval timer clock enable |
| aout_hiz | output | 1 | Analog output high-impedance control |
| strobe_ovr | output | 1 | Bus strobes forced by this block |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-fetch strobe level |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
A wrong mode register shows up at the clock enables and strobe pins on the very next edge. Every output is decoded from the same next-mode value, so a mode that is entered late, entered wrongly or never left is visible within one cycle of the stimulus. A wrong wake qualifier shows up as a pulse on `wake_pulse` and restored clocks while a masked line is held high, or as clocks that stay off while a qualifying line is held high. A control register that keeps its request bits after a wake, or that takes a write while asleep, shows on `ctl_rdata` on the following cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CTL_W   = 4;
  localparam int CB_IDLE = 0;
  localparam int CB_DOWN = 1;
  localparam int CB_SERW = 2;
  localparam int CB_EXTW = 3;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_mode_e;

  typedef struct packed {
    logic core;
    logic pll;
    logic periph;
    logic osc;
    logic tick;
    logic hiz;
    logic ovr;
    logic ale;
    logic psen;
  } pm_pins_t;

  function automatic pm_pins_t pm_decode(pm_mode_e m, logic osc_off);
    pm_pins_t p;
    p.core   = 1'b1;
    p.pll    = 1'b1;
    p.periph = 1'b1;
    p.osc    = 1'b1;
    p.tick   = 1'b1;
    p.hiz    = 1'b0;
    p.ovr    = 1'b0;
    p.ale    = 1'b1;
    p.psen   = 1'b1;
    case (m)
      PM_IDLE: begin
        p.core = 1'b0;
        p.ovr  = 1'b1;
      end
      PM_DOWN: begin
        p.core   = 1'b0;
        p.pll    = 1'b0;
        p.periph = 1'b0;
        p.osc    = ~osc_off;
        p.tick   = ~osc_off;
        p.hiz    = 1'b1;
        p.ovr    = 1'b1;
        p.ale    = 1'b0;
        p.psen   = 1'b0;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wake,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             pll_wr,
  input  logic             pll_osc_off,
  output logic [CTL_W-1:0] ctl_q,
  output logic             osc_off_q,
  output logic             osc_off_d
);

  localparam logic [CTL_W-1:0] REQ_MASK = (CTL_W'(1) << CB_IDLE) | (CTL_W'(1) << CB_DOWN);

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d     = ctl_q;
    osc_off_d = osc_off_q;
    if (wake) begin
      ctl_d = ctl_q & ~REQ_MASK;
    end else if (run) begin
      if (ctl_wr) ctl_d = ctl_wdata;
      if (pll_wr) osc_off_d = pll_osc_off;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      osc_off_q <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      osc_off_q <= osc_off_d;
    end
  end

endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int TICK_IDX = 2,
  parameter int SER_IDX  = 4,
  parameter int EXT0_IDX = 0
) (
  input  pm_mode_e           mode,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               ser_wake_en,
  input  logic               ext_wake_en,
  output logic               wake
);

  logic [NUM_IRQ-1:0] down_mask;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    if (i == TICK_IDX) begin : g_tick
      assign down_mask[i] = 1'b1;
    end else if (i == SER_IDX) begin : g_ser
      assign down_mask[i] = ser_wake_en;
    end else if (i == EXT0_IDX) begin : g_ext
      assign down_mask[i] = ext_wake_en;
    end else begin : g_off
      assign down_mask[i] = 1'b0;
    end
  end

  always_comb begin
    case (mode)
      PM_IDLE: wake = |irq_req;
      PM_DOWN: wake = |(irq_req & down_mask);
      default: wake = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_idle,
  input  logic     req_down,
  input  logic     wake,
  output pm_mode_e mode_q,
  output pm_mode_e mode_d,
  output logic     wake_pulse
);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      PM_RUN: begin
        if (req_down)      mode_d = PM_DOWN;
        else if (req_idle) mode_d = PM_IDLE;
      end
      PM_IDLE, PM_DOWN: begin
        if (wake) mode_d = PM_RUN;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_RUN;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      wake_pulse <= wake;
    end
  end

endmodule

// File: rtl/pmc_out_stage.sv
module pmc_out_stage
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_mode_e mode_d,
  input  logic     osc_off_d,
  output pm_pins_t pins_q
);

  localparam pm_pins_t PINS_RST = pm_decode(PM_RUN, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_RST;
    else     pins_q <= pm_decode(mode_d, osc_off_d);
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int TICK_IDX = 2,
  parameter int SER_IDX  = 4,
  parameter int EXT0_IDX = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               pll_wr,
  input  logic               pll_osc_off,
  input  logic [NUM_IRQ-1:0] irq_req,
  output logic [CTL_W-1:0]   ctl_rdata,
  output logic               osc_off_rd,
  output logic               core_clk_en,
  output logic               pll_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               tick_clk_en,
  output logic               aout_hiz,
  output logic               strobe_ovr,
  output logic               ale_lvl,
  output logic               psen_lvl,
  output logic               wake_pulse
);

  pm_mode_e         mode_q;
  pm_mode_e         mode_d;
  logic             wake;
  logic [CTL_W-1:0] ctl_q;
  logic             osc_off_q;
  logic             osc_off_d;
  pm_pins_t         pins_q;

  pmc_ctl_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .run         (mode_q == PM_RUN),
    .wake        (wake),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .pll_wr      (pll_wr),
    .pll_osc_off (pll_osc_off),
    .ctl_q       (ctl_q),
    .osc_off_q   (osc_off_q),
    .osc_off_d   (osc_off_d)
  );

  pmc_wake_qual #(
    .NUM_IRQ  (NUM_IRQ),
    .TICK_IDX (TICK_IDX),
    .SER_IDX  (SER_IDX),
    .EXT0_IDX (EXT0_IDX)
  ) u_qual (
    .mode        (mode_q),
    .irq_req     (irq_req),
    .ser_wake_en (ctl_q[CB_SERW]),
    .ext_wake_en (ctl_q[CB_EXTW]),
    .wake        (wake)
  );

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_idle   (ctl_q[CB_IDLE]),
    .req_down   (ctl_q[CB_DOWN]),
    .wake       (wake),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .wake_pulse (wake_pulse)
  );

  pmc_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .mode_d    (mode_d),
    .osc_off_d (osc_off_d),
    .pins_q    (pins_q)
  );

  assign ctl_rdata     = ctl_q;
  assign osc_off_rd    = osc_off_q;
  assign core_clk_en   = pins_q.core;
  assign pll_clk_en    = pins_q.pll;
  assign periph_clk_en = pins_q.periph;
  assign osc_en        = pins_q.osc;
  assign tick_clk_en   = pins_q.tick;
  assign aout_hiz      = pins_q.hiz;
  assign strobe_ovr    = pins_q.ovr;
  assign ale_lvl       = pins_q.ale;
  assign psen_lvl      = pins_q.psen;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int TICK_IDX = 2,
  parameter int SER_IDX  = 4,
  parameter int EXT0_IDX = 0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [CTL_W-1:0]   ctl_rdata,
  input logic               osc_off_rd,
  input logic               core_clk_en,
  input logic               pll_clk_en,
  input logic               periph_clk_en,
  input logic               osc_en,
  input logic               tick_clk_en,
  input logic               aout_hiz,
  input logic               strobe_ovr,
  input logic               ale_lvl,
  input logic               psen_lvl,
  input logic               wake_pulse
);

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (strobe_ovr && pll_clk_en) |-> (ale_lvl && psen_lvl && !aout_hiz && periph_clk_en && !core_clk_en)); // R2

  AST_DOWN_PINS: assert property (@(posedge clk) disable iff (rst)
    !pll_clk_en |-> (aout_hiz && strobe_ovr && !ale_lvl && !psen_lvl && !periph_clk_en && !core_clk_en)); // R3

  AST_DOWN_OSC_TICK: assert property (@(posedge clk) disable iff (rst)
    !pll_clk_en |-> (osc_en == !osc_off_rd && tick_clk_en == osc_en)); // R4

  AST_DOWN_WAKE_QUAL: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && !$past(pll_clk_en)) |->
      $past(irq_req[TICK_IDX] || (irq_req[SER_IDX] && ctl_rdata[CB_SERW]) ||
            (irq_req[EXT0_IDX] && ctl_rdata[CB_EXTW]))); // R7

  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (core_clk_en && pll_clk_en && !strobe_ovr && ctl_rdata[CB_DOWN:CB_IDLE] == 2'b00)); // R8

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R8

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en |=> (wake_pulse || ($stable(ctl_rdata) && $stable(osc_off_rd)))); // R9

endmodule

bind pwr_mode_ctrl pmc_checker #(
  .NUM_IRQ  (NUM_IRQ),
  .TICK_IDX (TICK_IDX),
  .SER_IDX  (SER_IDX),
  .EXT0_IDX (EXT0_IDX)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .irq_req       (irq_req),
  .ctl_rdata     (ctl_rdata),
  .osc_off_rd    (osc_off_rd),
  .core_clk_en   (core_clk_en),
  .pll_clk_en    (pll_clk_en),
  .periph_clk_en (periph_clk_en),
  .osc_en        (osc_en),
  .tick_clk_en   (tick_clk_en),
  .aout_hiz      (aout_hiz),
  .strobe_ovr    (strobe_ovr),
  .ale_lvl       (ale_lvl),
  .psen_lvl      (psen_lvl),
  .wake_pulse    (wake_pulse)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int NI   = 8;
  localparam int TIX  = 2;
  localparam int SIX  = 4;
  localparam int EIX  = 0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic          pll_wr = 1'b0;
  logic          pll_osc_off = 1'b0;
  logic [NI-1:0] irq_req = '0;
  logic [3:0]    ctl_rdata;
  logic          osc_off_rd, core_clk_en, pll_clk_en, periph_clk_en, osc_en, tick_clk_en;
  logic          aout_hiz, strobe_ovr, ale_lvl, psen_lvl, wake_pulse;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NI), .TICK_IDX(TIX), .SER_IDX(SIX), .EXT0_IDX(EIX)) u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .pll_wr(pll_wr),
    .pll_osc_off(pll_osc_off), .irq_req(irq_req), .ctl_rdata(ctl_rdata), .osc_off_rd(osc_off_rd),
    .core_clk_en(core_clk_en), .pll_clk_en(pll_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .tick_clk_en(tick_clk_en), .aout_hiz(aout_hiz), .strobe_ovr(strobe_ovr),
    .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .wake_pulse(wake_pulse)
  );

  // reference state: 0 run, 1 idle, 2 power-down
  int    m_mode = 0;
  int    m_ctl  = 0;
  int    m_osc  = 0;
  int    m_wake = 0;
  int    n_vec  = 0;
  int    n_bad  = 0;
  string scen   = "R1";

  task automatic chk(string sig, string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s, step %s): %s actual %0d expected %0d", tag, sig, scen, sig, act, exp);
    end
  endtask

  task automatic model_step();
    int w;
    int nm;
    if (rst) begin
      m_mode = 0; m_ctl = 0; m_osc = 0; m_wake = 0;
      return;
    end
    w = 0;
    if (m_mode == 1 && irq_req != 0) w = 1;
    if (m_mode == 2 && (irq_req[TIX] || (irq_req[SIX] && m_ctl[2]) || (irq_req[EIX] && m_ctl[3]))) w = 1;
    if (w == 1) begin
      m_mode = 0;
      m_ctl  = m_ctl & 12;
      m_wake = 1;
    end else begin
      m_wake = 0;
      if (m_mode == 0) begin
        nm = m_ctl[1] ? 2 : (m_ctl[0] ? 1 : 0);
        if (ctl_wr) m_ctl = int'(ctl_wdata);
        if (pll_wr) m_osc = int'(pll_osc_off);
        m_mode = nm;
      end
    end
  endtask

  task automatic compare();
    string mt;
    int e_core, e_pll, e_per, e_osc, e_hiz, e_ovr, e_lvl;
    mt = (m_mode == 2) ? "R3" : (m_mode == 1) ? "R2" : (scen == "R1") ? "R1" : "R8";
    e_core = (m_mode == 0) ? 1 : 0;
    e_pll  = (m_mode == 2) ? 0 : 1;
    e_per  = e_pll;
    e_osc  = (m_mode == 2) ? 1 - m_osc : 1;
    e_hiz  = (m_mode == 2) ? 1 : 0;
    e_ovr  = (m_mode == 0) ? 0 : 1;
    e_lvl  = (m_mode == 2) ? 0 : 1;
    chk("core_clk_en",   mt,   int'(core_clk_en),   e_core);
    chk("pll_clk_en",    mt,   int'(pll_clk_en),    e_pll);
    chk("periph_clk_en", mt,   int'(periph_clk_en), e_per);
    chk("aout_hiz",      mt,   int'(aout_hiz),      e_hiz);
    chk("strobe_ovr",    mt,   int'(strobe_ovr),    e_ovr);
    chk("ale_lvl",       mt,   int'(ale_lvl),       e_lvl);
    chk("psen_lvl",      mt,   int'(psen_lvl),      e_lvl);
    chk("osc_en",        "R4", int'(osc_en),        e_osc);
    chk("tick_clk_en",   "R4", int'(tick_clk_en),   e_osc);
    chk("ctl_rdata",     "R9", int'(ctl_rdata),     m_ctl);
    chk("osc_off_rd",    "R9", int'(osc_off_rd),    m_osc);
    chk("wake_pulse",    "R8", int'(wake_pulse),    m_wake);
  endtask

  task automatic cyc(input logic wr, input logic [3:0] wd, input logic pw, input logic po,
                     input logic [NI-1:0] irq);
    ctl_wr = wr; ctl_wdata = wd; pll_wr = pw; pll_osc_off = po; irq_req = irq;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 1'b0, 1'b0, '0);
  endtask

  task automatic put_ctl(logic [3:0] v);
    cyc(1'b1, v, 1'b0, 1'b0, '0);
  endtask

  task automatic put_osc(logic v);
    cyc(1'b0, 4'h0, 1'b1, v, '0);
  endtask

  task automatic pulse_irq(int idx);
    cyc(1'b0, 4'h0, 1'b0, 1'b0, NI'(1) << idx);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    scen = "R1";
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(2);

    scen = "R2";             // idle entry, then R6 wake on an arbitrary line
    put_ctl(4'b0001);
    wait_n(3);
    scen = "R6";
    pulse_irq(5);
    wait_n(2);
    scen = "R6";
    put_ctl(4'b0001);
    wait_n(1);
    pulse_irq(7);
    wait_n(1);

    scen = "R3";             // power-down with both wake enables, oscillator kept
    put_osc(1'b0);
    put_ctl(4'b1110);
    wait_n(2);
    scen = "R7";
    pulse_irq(5);            // unqualified line, no wake
    pulse_irq(1);
    wait_n(1);
    pulse_irq(SIX);          // serial enabled: wakes
    wait_n(2);

    scen = "R4";             // oscillator-off, no wake enables
    put_osc(1'b1);
    put_ctl(4'b0010);
    wait_n(2);
    scen = "R7";
    pulse_irq(SIX);
    pulse_irq(EIX);
    pulse_irq(6);
    scen = "R9";
    cyc(1'b1, 4'b0000, 1'b1, 1'b0, '0);
    wait_n(1);
    scen = "R7";
    pulse_irq(TIX);          // timer always wakes
    wait_n(2);

    scen = "R7";             // external-0 wake enabled only
    put_ctl(4'b1010);
    wait_n(1);
    pulse_irq(SIX);
    pulse_irq(EIX);
    wait_n(2);

    scen = "R5";             // both request bits
    put_osc(1'b0);
    put_ctl(4'b0011);
    wait_n(3);
    scen = "R8";
    pulse_irq(TIX);
    wait_n(2);

    scen = "R9";             // writes during idle ignored
    put_ctl(4'b0001);
    wait_n(1);
    cyc(1'b1, 4'b1110, 1'b1, 1'b1, '0);
    wait_n(1);
    pulse_irq(3);
    wait_n(1);

    scen = "R1";             // reset out of power-down
    put_ctl(4'b0010);
    wait_n(2);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule